// File: doc/BRIEF.md
# Multichannel Resampler Context Scheduler

This block lets one fractional resampler datapath serve several independent complex channels in turn. It holds the live register context of the active channel, counts the output samples the datapath produces in the current slot, and hands the datapath to the next channel once a programmed number of outputs has been reached. Channels are visited round robin from channel 0 up to the programmed channel count.

A second register set runs in the background. At each switch, the two sets trade places. The set that has just been retired is written to a local context RAM. Each channel owns a fixed block of words there, starting at channel index times the context size. The context of the channel after the next one is then read back into the same set. When that transfer has finished by the time a slot ends, the switch costs no idle cycle. When it has not, the scheduler stalls the datapath and raises a flag until the transfer is done.

The first time a channel is entered, it goes through a warm-up. First its coefficients are loaded. Then only the interpolation control and the sample register bank run until they report a first result. Only after that is the full datapath enabled. A per-channel flag records that warm-up has been done, so the channel skips it on every later visit.

Top module: `rsmp_ctx_sched`

## Requirements
- R1: After reset the block is idle: all enables and `stall_o` are low, `cur_ch_o` is 0, `init_o` is 0 and `ctx_o` is 0. It stays idle until `enable_i` is sampled high.
- R2: Warm-up order. On the clock edge where `enable_i` is sampled high, and on a switch into a channel whose flag is clear, `coef_load_o` rises. On the edge where `coef_done_i` is sampled, `coef_load_o` falls and `ipc_en_o`/`bank_en_o` rise without `dp_en_o`. On the edge where `prime_done_i` is sampled, `dp_en_o` rises as well. `dp_en_o` is never high without `ipc_en_o` and `bank_en_o`.
- R3: Bit c of `init_o` is set on the edge that ends channel c's warm-up. It is cleared only by reset. A switch into a channel whose bit is set goes straight to full run.
- R4: In run, each cycle with `out_valid_i` high counts one output. The output that brings the slot count to `slot_len_i` ends the slot; a value of 0 acts as 1. Counting restarts at every switch.
- R5: `ctx_o` holds the active context as CTX_WORDS words of CTX_W bits, with word k at bits [k*CTX_W +: CTX_W]. In run, `upd_en_i` writes `upd_data_i` into word `upd_idx_i`, and the new value is visible after the next edge.
- R6: Context updates offered while idle, in warm-up or in stall have no effect on `ctx_o`.
- R7: On re-entry, a channel's context equals its value at the end of its previous slot, including an update made in that slot's last cycle. A channel entered for the first time starts with an all-zero context.
- R8: After a switch, the background transfer takes CTX_WORDS cycles to save the retired context and then CTX_WORDS cycles to load the next-but-one channel; at start only the load runs. If the transfer is done when a slot ends, the switch takes effect on that edge and `dp_en_o` stays high across a switch into an initialised channel.
- R9: If a slot ends before the transfer is done, `stall_o` goes high and all enables go low from the next edge. The switch takes effect on the edge where the transfer is seen complete, and `stall_o` falls there.
- R10: `num_ch_i` lies in 2..NUM_CH and is held while enabled. `cur_ch_o` steps from c to c+1, wrapping to 0 after `num_ch_i`-1, and changes only at a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Start scheduling from channel 0 |
| num_ch_i | input | CH_W+1 | Number of channels in the rotation |
| slot_len_i | input | CNT_W | Output samples per slot |
| out_valid_i | input | 1 | Datapath produced one output sample |
| coef_done_i | input | 1 | Coefficient load finished |
| prime_done_i | input | 1 | Interpolation control and register bank produced first result |
| upd_en_i | input | 1 | Datapath writes one context word |
| upd_idx_i | input | IDX_W | Context word index |
| upd_data_i | input | CTX_W | Context word value |
| cur_ch_o | output | CH_W | Active channel |
| coef_load_o | output | 1 | Load coefficients |
| ipc_en_o | output | 1 | Enable interpolation control |
| bank_en_o | output | 1 | Enable sample register bank |
| dp_en_o | output | 1 | Enable full datapath |
| stall_o | output | 1 | Slot ended before context transfer finished |
| init_o | output | NUM_CH | Per-channel warm-up done flags |
| ctx_o | output | CTX_WORDS*CTX_W | Active register context |

## Verification
Every result of this block is registered once. A done input, an output count or a context write changes the outputs after the next rising edge, and a stall releases on the edge where the transfer is seen complete. The bench keeps a behavioural model of channel order, slot counting, the two context sets, the context RAM and the warm-up flags. The model advances on the same rising edge as the design, and every output is compared on the falling edge before new inputs are driven. Slot lengths shorter than, close to and longer than the 2*CTX_WORDS transfer, and rotations of 2, 3, 4 and 8 channels, exercise both the stall path and the switch that costs no idle cycle.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_COEF, PH_PRIME, PH_RUN, PH_STALL} phase_e;
  typedef enum logic [1:0] {XF_IDLE, XF_SAVE, XF_LOAD, XF_READY} xfer_e;
endpackage

// File: rtl/rsmp_ctx_ram.sv
module rsmp_ctx_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rsmp_ctx_xfer.sv
// Spare register set plus save/load sequencer over the context RAM.
module rsmp_ctx_xfer
  import rsmp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORDS  = 4,
  parameter int DW     = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               skip_save_i,
  input  logic [CH_W-1:0]    save_ch_i,
  input  logic [CH_W-1:0]    load_ch_i,
  input  logic               load_zero_i,
  input  logic               swap_i,
  input  logic [WORDS*DW-1:0] swap_in_i,
  output logic [WORDS*DW-1:0] spare_o,
  output logic               ready_o
);
  localparam int DEPTH = NUM_CH * WORDS;
  localparam int AW    = $clog2(DEPTH);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  xfer_e            st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CH_W-1:0]  sch_q, lch_q;
  logic             lz_q;
  logic [DW-1:0]    spare_q [WORDS];
  logic [AW-1:0]    waddr, raddr;
  logic [DW-1:0]    rdata;

  assign waddr = AW'(sch_q) * AW'(WORDS) + AW'(idx_q);
  assign raddr = AW'(lch_q) * AW'(WORDS) + AW'(idx_q);

  rsmp_ctx_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (st_q == XF_SAVE),
    .waddr_i (waddr),
    .wdata_i (spare_q[idx_q]),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= XF_IDLE;
      idx_q <= '0;
      sch_q <= '0;
      lch_q <= '0;
      lz_q  <= 1'b0;
      for (int k = 0; k < WORDS; k++) spare_q[k] <= '0;
    end else begin
      if (swap_i)
        for (int k = 0; k < WORDS; k++) spare_q[k] <= swap_in_i[k*DW +: DW];
      if (start_i) begin
        st_q  <= skip_save_i ? XF_LOAD : XF_SAVE;
        idx_q <= '0;
        sch_q <= save_ch_i;
        lch_q <= load_ch_i;
        lz_q  <= load_zero_i;
      end else begin
        unique case (st_q)
          XF_SAVE: begin
            if (idx_q == LAST) begin
              st_q  <= XF_LOAD;
              idx_q <= '0;
            end else idx_q <= idx_q + 1'b1;
          end
          XF_LOAD: begin
            spare_q[idx_q] <= lz_q ? '0 : rdata;
            if (idx_q == LAST) st_q <= XF_READY;
            else idx_q <= idx_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign spare_o[g*DW +: DW] = spare_q[g];
  end

  assign ready_o = (st_q == XF_READY);
endmodule

// File: rtl/rsmp_slot_cnt.sv
module rsmp_slot_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  // len 0 behaves as 1: count+1 >= len is then always true
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/rsmp_ctx_sched.sv
module rsmp_ctx_sched
  import rsmp_pkg::*;
#(
  parameter  int NUM_CH    = 8,
  parameter  int CTX_WORDS = 4,
  parameter  int CTX_W     = 16,
  parameter  int CNT_W     = 12,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int IDX_W     = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic [CH_W:0]              num_ch_i,
  input  logic [CNT_W-1:0]           slot_len_i,
  input  logic                       out_valid_i,
  input  logic                       coef_done_i,
  input  logic                       prime_done_i,
  input  logic                       upd_en_i,
  input  logic [IDX_W-1:0]           upd_idx_i,
  input  logic [CTX_W-1:0]           upd_data_i,
  output logic [CH_W-1:0]            cur_ch_o,
  output logic                       coef_load_o,
  output logic                       ipc_en_o,
  output logic                       bank_en_o,
  output logic                       dp_en_o,
  output logic                       stall_o,
  output logic [NUM_CH-1:0]          init_o,
  output logic [CTX_WORDS*CTX_W-1:0] ctx_o
);
  localparam int FLAT = CTX_WORDS * CTX_W;

  function automatic logic [CH_W-1:0] succ(input logic [CH_W-1:0] c, input logic [CH_W:0] n);
    logic [CH_W:0] inc;
    inc = {1'b0, c} + 1'b1;
    return (inc >= n) ? '0 : inc[CH_W-1:0];
  endfunction

  phase_e            ph_q;
  logic [CH_W-1:0]   cur_q, nxt_ch, nxt2_ch, load_ch;
  logic [NUM_CH-1:0] init_q;
  logic [CTX_W-1:0]  act_q   [CTX_WORDS];
  logic [CTX_W-1:0]  act_upd [CTX_WORDS];
  logic [CTX_W-1:0]  spare_w [CTX_WORDS];
  logic [FLAT-1:0]   upd_flat, spare_flat;
  logic              run, upd_ok, last, slot_end, do_sw, start_xf, idle;
  logic              xf_ready;

  assign idle     = (ph_q == PH_IDLE);
  assign run      = (ph_q == PH_RUN);
  assign upd_ok   = run && upd_en_i;
  assign nxt_ch   = succ(cur_q, num_ch_i);
  assign nxt2_ch  = succ(nxt_ch, num_ch_i);
  assign slot_end = run && out_valid_i && last;
  assign do_sw    = (slot_end || ph_q == PH_STALL) && xf_ready;
  assign start_xf = do_sw || (idle && enable_i);
  assign load_ch  = idle ? succ('0, num_ch_i) : nxt2_ch;

  always_comb begin
    act_upd = act_q;
    if (upd_ok) act_upd[upd_idx_i] = upd_data_i;
  end

  for (genvar g = 0; g < CTX_WORDS; g++) begin : g_ctx
    assign upd_flat[g*CTX_W +: CTX_W] = act_upd[g];
    assign spare_w[g]                 = spare_flat[g*CTX_W +: CTX_W];
    assign ctx_o[g*CTX_W +: CTX_W]    = act_q[g];
  end

  rsmp_slot_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (do_sw || idle),
    .inc_i  (run && out_valid_i && !slot_end),
    .len_i  (slot_len_i),
    .last_o (last)
  );

  rsmp_ctx_xfer #(.NUM_CH(NUM_CH), .WORDS(CTX_WORDS), .DW(CTX_W), .CH_W(CH_W)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_xf),
    .skip_save_i (idle),
    .save_ch_i   (cur_q),
    .load_ch_i   (load_ch),
    .load_zero_i (!init_q[load_ch]),
    .swap_i      (do_sw),
    .swap_in_i   (upd_flat),
    .spare_o     (spare_flat),
    .ready_o     (xf_ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cur_q  <= '0;
      init_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE:  if (enable_i) begin
                    ph_q  <= PH_COEF;
                    cur_q <= '0;
                  end
        PH_COEF:  if (coef_done_i) ph_q <= PH_PRIME;
        PH_PRIME: if (prime_done_i) begin
                    ph_q          <= PH_RUN;
                    init_q[cur_q] <= 1'b1;
                  end
        default: begin
          if (do_sw) begin
            cur_q <= nxt_ch;
            ph_q  <= init_q[nxt_ch] ? PH_RUN : PH_COEF;
          end else if (slot_end) ph_q <= PH_STALL;
        end
      endcase
    end
  end

  // active set: swapped with the spare set on a switch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      for (int k = 0; k < CTX_WORDS; k++) act_q[k] <= '0;
    else if (do_sw)
      for (int k = 0; k < CTX_WORDS; k++) act_q[k] <= spare_w[k];
    else if (upd_ok)
      act_q[upd_idx_i] <= upd_data_i;
  end

  assign cur_ch_o    = cur_q;
  assign coef_load_o = (ph_q == PH_COEF);
  assign ipc_en_o    = (ph_q == PH_PRIME) || run;
  assign bank_en_o   = (ph_q == PH_PRIME) || run;
  assign dp_en_o     = run;
  assign stall_o     = (ph_q == PH_STALL);
  assign init_o      = init_q;
endmodule

// File: rtl/rsmp_ctx_sched_chk.sv
module rsmp_ctx_sched_chk #(
  parameter int NUM_CH = 8,
  parameter int FLAT   = 64,
  parameter int CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_valid_i,
  input logic              coef_load_o,
  input logic              ipc_en_o,
  input logic              bank_en_o,
  input logic              dp_en_o,
  input logic              stall_o,
  input logic [CH_W-1:0]   cur_ch_o,
  input logic [NUM_CH-1:0] init_o,
  input logic [FLAT-1:0]   ctx_o,
  input logic              xf_ready
);
  AST_DP_NEEDS_PARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_en_o |-> (ipc_en_o && bank_en_o)); // R2
  AST_WARMUP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_load_o |=> (coef_load_o || (ipc_en_o && bank_en_o && !dp_en_o))); // R2
  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_o & $past(init_o)) == $past(init_o)); // R3
  AST_CH_MOVES_AT_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_ch_o) |-> $past(dp_en_o || stall_o)); // R10
  AST_IDLE_CTX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dp_en_o && !stall_o) |=> $stable(ctx_o)); // R6
  AST_STALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(dp_en_o && out_valid_i)); // R9
  AST_STALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && xf_ready) |=> (!stall_o && cur_ch_o != $past(cur_ch_o))); // R9
endmodule

bind rsmp_ctx_sched rsmp_ctx_sched_chk #(
  .NUM_CH(NUM_CH), .FLAT(CTX_WORDS*CTX_W), .CH_W(CH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_i),
  .coef_load_o (coef_load_o),
  .ipc_en_o    (ipc_en_o),
  .bank_en_o   (bank_en_o),
  .dp_en_o     (dp_en_o),
  .stall_o     (stall_o),
  .cur_ch_o    (cur_ch_o),
  .init_o      (init_o),
  .ctx_o       (ctx_o),
  .xf_ready    (xf_ready)
);

// File: tb/sim_rsmp_ctx_sched.sv
`timescale 1ns/1ps
module sim_rsmp_ctx_sched;
  localparam int NUM_CH = 8;
  localparam int WORDS  = 4;
  localparam int DW     = 16;
  localparam int CNT_W  = 12;
  localparam int CH_W   = 3;
  localparam int IDX_W  = 2;
  localparam int FLAT   = WORDS * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CH_W:0] num_ch = 4'd2;
  logic [CNT_W-1:0] slot_len = '0;
  logic out_valid = 1'b0, coef_done = 1'b0, prime_done = 1'b0, upd_en = 1'b0;
  logic [IDX_W-1:0] upd_idx = '0;
  logic [DW-1:0] upd_data = '0;
  logic [CH_W-1:0] cur_ch;
  logic coef_load, ipc_en, bank_en, dp_en, stall;
  logic [NUM_CH-1:0] init;
  logic [FLAT-1:0] ctx;

  always #2.5 clk = ~clk;

  rsmp_ctx_sched #(.NUM_CH(NUM_CH), .CTX_WORDS(WORDS), .CTX_W(DW), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .num_ch_i(num_ch),
    .slot_len_i(slot_len), .out_valid_i(out_valid), .coef_done_i(coef_done),
    .prime_done_i(prime_done), .upd_en_i(upd_en), .upd_idx_i(upd_idx),
    .upd_data_i(upd_data), .cur_ch_o(cur_ch), .coef_load_o(coef_load),
    .ipc_en_o(ipc_en), .bank_en_o(bank_en), .dp_en_o(dp_en), .stall_o(stall),
    .init_o(init), .ctx_o(ctx)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // behavioural reference: 0 idle 1 coef 2 prime 3 run 4 stall; xfer 0 idle 1 save 2 load 3 ready
  int m_ph, m_cur, m_cnt, m_xf, m_xi, m_sch, m_lch, m_nsw;
  bit m_lz, m_ign, m_swd;
  logic [DW-1:0] m_act [WORDS];
  logic [DW-1:0] m_spr [WORDS];
  logic [DW-1:0] m_ram [NUM_CH*WORDS];
  bit m_ini [NUM_CH];

  function automatic int succ(int c, int n);
    return (c + 1 >= n) ? 0 : c + 1;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_cur = 0; m_cnt = 0; m_xf = 0; m_xi = 0; m_sch = 0; m_lch = 0;
    m_lz = 0; m_ign = 0; m_swd = 0;
    for (int k = 0; k < WORDS; k++) begin m_act[k] = '0; m_spr[k] = '0; end
    for (int c = 0; c < NUM_CH; c++) m_ini[c] = 1'b0;
  endtask

  task automatic model_step();
    logic [DW-1:0] a2 [WORDS];
    logic [DW-1:0] tmp [WORDS];
    bit run, se, sw, rdy;
    int n, nch;
    nch = int'(num_ch);
    rdy = (m_xf == 3);
    run = (m_ph == 3);
    a2 = m_act;
    if (run && upd_en) a2[upd_idx] = upd_data;
    se = run && out_valid && (m_cnt + 1 >= int'(slot_len));
    sw = (se || m_ph == 4) && rdy;
    m_ign = upd_en && !run;
    m_swd = 1'b0;
    if (m_xf == 1) begin
      m_ram[m_sch*WORDS + m_xi] = m_spr[m_xi];
      if (m_xi == WORDS-1) begin m_xf = 2; m_xi = 0; end else m_xi++;
    end else if (m_xf == 2) begin
      m_spr[m_xi] = m_lz ? '0 : m_ram[m_lch*WORDS + m_xi];
      if (m_xi == WORDS-1) m_xf = 3; else m_xi++;
    end
    case (m_ph)
      0: if (enable) begin
           m_ph = 1; m_cur = 0; m_xf = 2; m_xi = 0;
           m_lch = succ(0, nch); m_lz = !m_ini[m_lch];
         end
      1: if (coef_done) m_ph = 2;
      2: if (prime_done) begin m_ph = 3; m_ini[m_cur] = 1'b1; end
      default: begin
        if (sw) begin
          tmp = m_spr; n = succ(m_cur, nch);
          m_spr = a2; m_act = tmp; m_sch = m_cur; m_cur = n; m_cnt = 0;
          m_ph = m_ini[n] ? 3 : 1; m_xf = 1; m_xi = 0;
          m_lch = succ(n, nch); m_lz = !m_ini[m_lch]; m_swd = 1'b1; m_nsw++;
        end else begin
          m_act = a2;
          if (se) m_ph = 4;
          else if (run && out_valid) m_cnt++;
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(bit ok, string req, string what, logic [FLAT-1:0] act, logic [FLAT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [FLAT-1:0] e_ctx;
    logic [NUM_CH-1:0] e_ini;
    string rq;
    for (int k = 0; k < WORDS; k++) e_ctx[k*DW +: DW] = m_act[k];
    for (int c = 0; c < NUM_CH; c++) e_ini[c] = m_ini[c];
    chk(cur_ch == CH_W'(m_cur), "R10", "cur_ch", FLAT'(cur_ch), FLAT'(m_cur));
    chk(coef_load == (m_ph == 1), "R2", "coef_load", FLAT'(coef_load), FLAT'(m_ph == 1));
    chk(ipc_en == (m_ph == 2 || m_ph == 3) && bank_en == ipc_en, "R2", "ipc_bank",
        FLAT'({ipc_en, bank_en}), FLAT'({2{m_ph == 2 || m_ph == 3}}));
    chk(dp_en == (m_ph == 3), "R8", "dp_en", FLAT'(dp_en), FLAT'(m_ph == 3));
    chk(stall == (m_ph == 4), "R9", "stall", FLAT'(stall), FLAT'(m_ph == 4));
    chk(init == e_ini, "R3", "init", FLAT'(init), FLAT'(e_ini));
    rq = m_swd ? "R7" : (m_ign ? "R6" : "R5");
    chk(ctx == e_ctx, rq, "ctx", ctx, e_ctx);
  endtask

  task automatic drive();
    coef_done  = coef_load && ($urandom % 3 == 0);
    prime_done = ipc_en && !dp_en && ($urandom % 2 == 0);
    out_valid  = ($urandom % 4) != 0;
    upd_en     = $urandom % 2;
    upd_idx    = IDX_W'($urandom % WORDS);
    upd_data   = DW'($urandom);
  endtask

  int n_stall, n_gapless, n_obs_sw;
  logic [NUM_CH-1:0] seen;

  task automatic scenario(int nch, int len, int cycles);
    bit pdp;
    logic [CH_W-1:0] pcur;
    rst_n = 1'b0; enable = 1'b0; upd_en = 1'b0; out_valid = 1'b0;
    coef_done = 1'b0; prime_done = 1'b0;
    repeat (3) @(negedge clk);
    num_ch = (CH_W+1)'(nch);
    slot_len = CNT_W'(len);
    m_nsw = 0; n_stall = 0; n_gapless = 0; n_obs_sw = 0; seen = '0;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!coef_load && !ipc_en && !bank_en && !dp_en && !stall, "R1", "enables",
        FLAT'({coef_load, ipc_en, bank_en, dp_en, stall}), '0);
    chk(cur_ch == '0 && init == '0, "R1", "cur_init", FLAT'({cur_ch, init}), '0);
    chk(ctx == '0, "R1", "ctx", ctx, '0);
    // idle with update traffic: R1 and R6
    for (int i = 0; i < 5; i++) begin
      drive();
      @(negedge clk);
      compare();
    end
    chk(!coef_load && ctx == '0, "R1", "idle_hold", FLAT'(coef_load) | ctx, '0);
    enable = 1'b1;
    pdp = 1'b0; pcur = '0;
    for (int i = 0; i < cycles; i++) begin
      drive();
      @(negedge clk);
      compare();
      if (stall) n_stall++;
      if (cur_ch != pcur) n_obs_sw++;
      if (dp_en && pdp && cur_ch != pcur) n_gapless++;
      seen[cur_ch] = 1'b1;
      pdp = dp_en; pcur = cur_ch;
    end
    chk(n_obs_sw == m_nsw, "R4", "switch_count", FLAT'(n_obs_sw), FLAT'(m_nsw));
  endtask

  initial begin
    // R4 R8: long slots, no stall, switches without a gap
    scenario(4, 20, 3000);
    chk(n_stall == 0, "R8", "no_stall", FLAT'(n_stall), '0);
    chk(n_gapless > 0, "R8", "gapless_switch", FLAT'(n_gapless), FLAT'(1));
    // R9: slots far shorter than the transfer
    scenario(3, 2, 3000);
    chk(n_stall > 0, "R9", "stall_seen", FLAT'(n_stall), FLAT'(1));
    // R4 R10: slot length 0 acts as 1, full rotation
    scenario(NUM_CH, 0, 3000);
    chk(seen == '1, "R10", "all_channels", FLAT'(seen), FLAT'({NUM_CH{1'b1}}));
    chk(init == '1, "R3", "all_init", FLAT'(init), FLAT'({NUM_CH{1'b1}}));
    // R7: two channels, slot near the transfer length
    scenario(2, 9, 3000);
    chk(m_nsw > 10, "R4", "switches_2ch", FLAT'(m_nsw), FLAT'(11));
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule